// File: doc/BRIEF.md
# EEPROM Page-Buffer Write Controller

This block is the write path between an AHB-Lite bus and a data EEPROM whose array port is 16 bits wide. Bus writes to the EEPROM window do not reach the array directly. They are collected in a 64-byte page buffer. Each written byte is recorded in a per-byte dirty mask. While the data is stored, the bus is stalled for a number of wait states. That number depends on the transfer width and on a fast/slow mode input. A 32-bit write is carried out as two 16-bit buffer accesses, which is why it costs more wait states.

Committing the page is a second, separate step. Software writes a start bit in a control register. The controller then scans the buffer and issues one 16-bit array write for each dirty halfword, all into a single row. A busy period stands in for the real program time, and it is set by a parameter. When it ends, the buffer and its mask are cleared and a completion flag is raised. The bus address space is split into four windows:

- control registers
- EEPROM data
- an undefined area that answers with an error
- a flash area that is acknowledged but has no effect

Top module: `pgbuf_write_ctrl`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0, mem_we is 0, the status register reads 0 and every page-buffer location reads 0.
- R2: With fast_mode=1, an EEPROM-window write of size word (hsize=2) holds hreadyout low for exactly 5 cycles. A byte (hsize=0) or halfword (hsize=1) write holds it low for exactly 2 cycles.
- R3: With fast_mode=0, the same writes hold hreadyout low for exactly 7 cycles (word) and 3 cycles (byte or halfword). No data phase is ever stalled longer than 7 cycles.
- R4: Byte and halfword writes update only the addressed bytes, with little-endian lanes: byte lane = haddr[1:0] and halfword lane = haddr[1]. Reads of the EEPROM window return the buffer word at haddr[5:2] with zero wait states.
- R5: A word write stores hwdata[15:0] at halfword index {haddr[5:2],0} and hwdata[31:16] at index {haddr[5:2],1}.
- R6: Writing 1 to bit 0 of the control register (offset 0x000) starts programming. The status register (offset 0x004) reports busy in bit 0 and done in bit 1. Busy reads 1 from the cycle after the start write until programming ends.
- R7: Programming issues one mem_we pulse per halfword that has any dirty byte, in ascending mem_col order. mem_be is set to that halfword's dirty bits and mem_wdata to its contents. mem_row equals haddr[11:6] of the most recent accepted EEPROM write.
- R8: An EEPROM-window write that arrives while busy is 1 gets a two-cycle ERROR response: first hreadyout=0 with hresp=1, then hreadyout=1 with hresp=1. The page buffer is left unchanged.
- R9: Any read or write in the undefined window (0x2000 to 0x2FFF, and at or above 0x2B000) gets the same two-cycle ERROR response.
- R10: Flash-window accesses (0x3000 to 0x2AFFF) complete with zero wait states and an OKAY response, read as 0, and leave the page buffer unchanged.
- R11: When programming ends, the page buffer and dirty mask are cleared and done is set. Done clears after a status read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address (offset into the block's space) |
| htrans | input | 2 | Transfer type; NONSEQ/SEQ start a transfer |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready from the previous data phase |
| fast_mode | input | 1 | 1 selects the short wait-state set |
| hreadyout | output | 1 | Data phase completes when high |
| hresp | output | 1 | 1 = ERROR response |
| hrdata | output | 32 | Read data |
| mem_we | output | 1 | Array halfword write strobe |
| mem_row | output | ROW_W | Array row being programmed |
| mem_col | output | IDX_W | Halfword column within the row |
| mem_wdata | output | 16 | Halfword write data |
| mem_be | output | 2 | Byte enables for mem_wdata |

## Verification
The write path is driven with word, byte and halfword transfers at several lanes, in both modes. The stall lengths 5/2 and 7/3 separate the width decode from the mode decode. Reading back the odd and even lanes shows whether a byte write disturbed its neighbour and whether the two halves of a word landed at the right indices. One page is then programmed with a mix of full, partial-upper and partial-lower halfwords, which exposes errors in scan order, byte enables and row selection. Writes made during the busy period, undefined-window accesses and flash accesses each check a distinct way that an access must be refused or ignored.

// File: rtl/pgbuf_pkg.sv
// Shared types and address-window constants for the EEPROM page-buffer
// write controller. Assumes byte addresses are offsets into the block's
// own space (the bus fabric strips the base).
package pgbuf_pkg;

    typedef enum logic [1:0] {
        WIN_REG   = 2'd0,
        WIN_EE    = 2'd1,
        WIN_UNDEF = 2'd2,
        WIN_FLASH = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_WAIT = 2'd1,
        BS_ERR1 = 2'd2,
        BS_ERR2 = 2'd3
    } bus_st_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_SCAN = 2'd1,
        PS_HOLD = 2'd2
    } prog_st_e;

    localparam logic [31:0] EE_BASE     = 32'h0000_1000;
    localparam logic [31:0] UNDEF_BASE  = 32'h0000_2000;
    localparam logic [31:0] FLASH_BASE  = 32'h0000_3000;
    localparam logic [31:0] FLASH_BYTES = 32'd163840;
    localparam int          EE_BYTES    = 4096;

    localparam int          REG_OFF_W   = 12;
    localparam logic [REG_OFF_W-1:0] CTRL_OFF = 12'h000;
    localparam logic [REG_OFF_W-1:0] STAT_OFF = 12'h004;

    localparam logic [2:0]  SZ_BYTE = 3'd0;
    localparam logic [2:0]  SZ_HALF = 3'd1;
    localparam logic [2:0]  SZ_WORD = 3'd2;

endpackage

// File: rtl/pgbuf_win_decode.sv
// Address window decoder: classifies a byte address as register, EEPROM,
// undefined or flash. Purely combinational. Assumes ADDR_W < 32.
module pgbuf_win_decode
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win
);

    logic [31:0] a32;
    assign a32 = 32'(addr);

    // Compare the address against the ascending window boundaries.
    always_comb begin
        if (a32 < EE_BASE)                       win = WIN_REG;
        else if (a32 < UNDEF_BASE)               win = WIN_EE;
        else if (a32 < FLASH_BASE)               win = WIN_UNDEF;
        else if (a32 < FLASH_BASE + FLASH_BYTES) win = WIN_FLASH;
        else                                     win = WIN_UNDEF;
    end

endmodule

// File: rtl/pgbuf_bus_fsm.sv
// AHB-Lite slave data-phase engine. Captures each accepted address phase,
// inserts width- and mode-dependent wait states for EEPROM writes, splits
// word writes into two halfword buffer writes, answers undefined and
// busy-time EEPROM writes with a two-cycle ERROR, and serves zero-wait
// register, buffer and flash accesses. Assumes every wait count is >= 1
// and the master holds hwdata for the whole data phase.
module pgbuf_bus_fsm
    import pgbuf_pkg::*;
#(
    parameter int PAGE_BYTES     = 64,
    parameter int ROW_W          = 6,
    parameter int FAST_WORD_WS   = 5,
    parameter int FAST_NARROW_WS = 2,
    parameter int SLOW_WORD_WS   = 7,
    parameter int SLOW_NARROW_WS = 3,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int IDX_W = OFF_W - 1,
    localparam int WD_W  = OFF_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsel,
    input  logic [REG_OFF_W-1:0] haddr_lo,
    input  win_e                 addr_win,
    input  logic [1:0]           htrans,
    input  logic                 hwrite,
    input  logic [2:0]           hsize,
    input  logic [31:0]          hwdata,
    input  logic                 hready,
    input  logic                 fast_mode,
    input  logic                 prog_busy,
    input  logic                 prog_done,
    input  logic [31:0]          buf_rd_word,
    output logic                 hreadyout,
    output logic                 hresp,
    output logic [31:0]          hrdata,
    output logic                 buf_we,
    output logic [IDX_W-1:0]     buf_idx,
    output logic [15:0]          buf_data,
    output logic [1:0]           buf_be,
    output logic [ROW_W-1:0]     buf_row,
    output logic [WD_W-1:0]      buf_rd_idx,
    output logic                 start_pulse,
    output logic                 status_rd
);

    localparam int WS_W = $clog2(SLOW_WORD_WS + 1);

    bus_st_e              st_q;
    logic [WS_W-1:0]      cnt_q;
    logic                 first_q;
    logic                 dp_valid_q;
    win_e                 dp_win_q;
    logic                 dp_write_q;
    logic [REG_OFF_W-1:0] dp_off_q;
    logic [2:0]           dp_size_q;

    logic            accept;
    logic [WS_W-1:0] ws_sel;
    logic            in_wait, last_wait, dp_word, zero_phase;
    logic [7:0]      byte_sel;

    // Phase-completion and error outputs follow directly from the state.
    assign hreadyout = !((st_q == BS_ERR1) || ((st_q == BS_WAIT) && (cnt_q != '0)));
    assign hresp     = (st_q == BS_ERR1) || (st_q == BS_ERR2);
    assign accept    = hsel && hready && ((htrans == 2'b10) || (htrans == 2'b11));

    // Wait-state count for the transfer in its address phase.
    always_comb begin
        if (hsize == SZ_WORD) ws_sel = fast_mode ? WS_W'(FAST_WORD_WS)   : WS_W'(SLOW_WORD_WS);
        else                  ws_sel = fast_mode ? WS_W'(FAST_NARROW_WS) : WS_W'(SLOW_NARROW_WS);
    end

    // Data-phase sequencing: capture address phase, count waits, step errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= BS_IDLE;
            cnt_q      <= '0;
            first_q    <= 1'b0;
            dp_valid_q <= 1'b0;
            dp_win_q   <= WIN_REG;
            dp_write_q <= 1'b0;
            dp_off_q   <= '0;
            dp_size_q  <= '0;
        end else if (hreadyout) begin
            dp_valid_q <= accept;
            first_q    <= 1'b0;
            if (accept) begin
                dp_win_q   <= addr_win;
                dp_write_q <= hwrite;
                dp_off_q   <= haddr_lo;
                dp_size_q  <= hsize;
                if ((addr_win == WIN_UNDEF) || ((addr_win == WIN_EE) && hwrite && prog_busy)) begin
                    st_q <= BS_ERR1;
                end else if ((addr_win == WIN_EE) && hwrite) begin
                    st_q    <= BS_WAIT;
                    cnt_q   <= ws_sel;
                    first_q <= 1'b1;
                end else begin
                    st_q <= BS_IDLE;
                end
            end else begin
                st_q <= BS_IDLE;
            end
        end else if (st_q == BS_ERR1) begin
            st_q <= BS_ERR2;
        end else begin
            cnt_q   <= cnt_q - 1'b1;
            first_q <= 1'b0;
        end
    end

    assign in_wait   = (st_q == BS_WAIT);
    assign last_wait = in_wait && (cnt_q == '0);
    assign dp_word   = (dp_size_q == SZ_WORD);
    assign byte_sel  = hwdata[{dp_off_q[1:0], 3'b000} +: 8];
    assign buf_row   = dp_off_q[OFF_W+ROW_W-1:OFF_W];

    // Buffer write port: low half of a word first, everything else last.
    always_comb begin
        buf_we   = 1'b0;
        buf_idx  = dp_off_q[OFF_W-1:1];
        buf_data = hwdata[15:0];
        buf_be   = 2'b11;
        if (in_wait && dp_word && first_q) begin
            buf_we  = 1'b1;
            buf_idx = {dp_off_q[OFF_W-1:2], 1'b0};
        end else if (last_wait) begin
            buf_we = 1'b1;
            if (dp_word) begin
                buf_idx  = {dp_off_q[OFF_W-1:2], 1'b1};
                buf_data = hwdata[31:16];
            end else if (dp_size_q == SZ_HALF) begin
                buf_data = dp_off_q[1] ? hwdata[31:16] : hwdata[15:0];
            end else begin
                buf_data = {byte_sel, byte_sel};
                buf_be   = dp_off_q[0] ? 2'b10 : 2'b01;
            end
        end
    end

    assign zero_phase  = (st_q == BS_IDLE) && dp_valid_q;
    assign buf_rd_idx  = dp_off_q[OFF_W-1:2];
    assign start_pulse = zero_phase && (dp_win_q == WIN_REG) && dp_write_q
                         && (dp_off_q == CTRL_OFF) && hwdata[0];
    assign status_rd   = zero_phase && (dp_win_q == WIN_REG) && !dp_write_q
                         && (dp_off_q == STAT_OFF);

    // Read data mux for zero-wait read data phases.
    always_comb begin
        hrdata = '0;
        if (zero_phase && !dp_write_q) begin
            if (status_rd)                hrdata = {30'd0, prog_done, prog_busy};
            else if (dp_win_q == WIN_EE)  hrdata = buf_rd_word;
        end
    end

endmodule

// File: rtl/pgbuf_page_buffer.sv
// Page buffer: halfword-organised storage with a per-byte dirty mask and
// the latched target row. One byte-enabled write port, one word read port
// for the bus, one halfword scan port for programming, and a clear.
module pgbuf_page_buffer #(
    parameter int PAGE_BYTES = 64,
    parameter int ROW_W      = 6,
    localparam int HW_CNT = PAGE_BYTES / 2,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int IDX_W  = OFF_W - 1,
    localparam int WD_W   = OFF_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [15:0]      wr_data,
    input  logic [1:0]       wr_be,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             clr,
    input  logic [WD_W-1:0]  rd_idx,
    output logic [31:0]      rd_word,
    input  logic [IDX_W-1:0] scan_idx,
    output logic [15:0]      scan_data,
    output logic [1:0]       scan_be,
    output logic [ROW_W-1:0] row_q
);

    logic [15:0] hw_q    [HW_CNT];
    logic [1:0]  dirty_q [HW_CNT];

    for (genvar g = 0; g < HW_CNT; g++) begin : g_hw
        for (genvar b = 0; b < 2; b++) begin : g_lane
            // One byte lane: write when enabled, clear after programming.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    hw_q[g][8*b +: 8] <= '0;
                    dirty_q[g][b]     <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(g)) && wr_be[b]) begin
                    hw_q[g][8*b +: 8] <= wr_data[8*b +: 8];
                    dirty_q[g][b]     <= 1'b1;
                end
            end
        end
    end

    // Row of the most recent buffer write.
    always_ff @(posedge clk) begin
        if (!rst_n)     row_q <= '0;
        else if (wr_en) row_q <= wr_row;
    end

    assign rd_word   = {hw_q[{rd_idx, 1'b1}], hw_q[{rd_idx, 1'b0}]};
    assign scan_data = hw_q[scan_idx];
    assign scan_be   = dirty_q[scan_idx];

endmodule

// File: rtl/pgbuf_prog_seq.sv
// Programming sequencer: on start, scans every halfword of the buffer and
// issues an array write for each dirty one, then holds busy for the
// simulated program time, clears the buffer and sets done. Done clears
// on a status read unless it is being set in the same cycle.
module pgbuf_prog_seq
    import pgbuf_pkg::*;
#(
    parameter int HW_CNT      = 32,
    parameter int PROG_CYCLES = 40,
    localparam int IDX_W = $clog2(HW_CNT),
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             status_rd,
    input  logic [1:0]       scan_be,
    output logic [IDX_W-1:0] scan_idx,
    output logic             mem_we,
    output logic             busy,
    output logic             done,
    output logic             buf_clr
);

    prog_st_e         st_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] hold_q;

    assign scan_idx = idx_q;
    assign busy     = (st_q != PS_IDLE);
    assign mem_we   = (st_q == PS_SCAN) && (scan_be != 2'b00);
    assign buf_clr  = (st_q == PS_HOLD) && (hold_q == '0);

    // Scan / hold / return-to-idle sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PS_IDLE;
            idx_q  <= '0;
            hold_q <= '0;
        end else begin
            case (st_q)
                PS_IDLE: if (start) begin
                    st_q  <= PS_SCAN;
                    idx_q <= '0;
                end
                PS_SCAN: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(HW_CNT - 1)) begin
                        st_q   <= PS_HOLD;
                        hold_q <= CNT_W'(PROG_CYCLES - 1);
                    end
                end
                PS_HOLD: begin
                    if (hold_q == '0) st_q <= PS_IDLE;
                    else              hold_q <= hold_q - 1'b1;
                end
                default: st_q <= PS_IDLE;
            endcase
        end
    end

    // Completion flag: set at the end of programming, cleared by reading.
    always_ff @(posedge clk) begin
        if (!rst_n)         done <= 1'b0;
        else if (buf_clr)   done <= 1'b1;
        else if (status_rd) done <= 1'b0;
    end

endmodule

// File: rtl/pgbuf_write_ctrl.sv
// Top of the EEPROM page-buffer write controller: wires the window decoder,
// the bus data-phase engine, the page buffer and the programming sequencer.
// Assumes a single AHB-Lite master and ADDR_W between 12 and 31.
module pgbuf_write_ctrl
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W         = 18,
    parameter int PAGE_BYTES     = 64,
    parameter int PROG_CYCLES    = 40,
    parameter int FAST_WORD_WS   = 5,
    parameter int FAST_NARROW_WS = 2,
    parameter int SLOW_WORD_WS   = 7,
    parameter int SLOW_NARROW_WS = 3,
    localparam int HW_CNT = PAGE_BYTES / 2,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int IDX_W  = OFF_W - 1,
    localparam int WD_W   = OFF_W - 2,
    localparam int ROW_W  = $clog2(EE_BYTES) - OFF_W
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [31:0]       hwdata,
    input  logic              hready,
    input  logic              fast_mode,
    output logic              hreadyout,
    output logic              hresp,
    output logic [31:0]       hrdata,
    output logic              mem_we,
    output logic [ROW_W-1:0]  mem_row,
    output logic [IDX_W-1:0]  mem_col,
    output logic [15:0]       mem_wdata,
    output logic [1:0]        mem_be
);

    win_e             addr_win;
    logic             buf_we, buf_clr, start_pulse, status_rd;
    logic [IDX_W-1:0] buf_idx, scan_idx;
    logic [15:0]      buf_data;
    logic [1:0]       buf_be, scan_be;
    logic [ROW_W-1:0] buf_row;
    logic [WD_W-1:0]  buf_rd_idx;
    logic [31:0]      buf_rd_word;
    logic             prog_busy, prog_done;

    pgbuf_win_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr (haddr),
        .win  (addr_win)
    );

    pgbuf_bus_fsm #(
        .PAGE_BYTES     (PAGE_BYTES),
        .ROW_W          (ROW_W),
        .FAST_WORD_WS   (FAST_WORD_WS),
        .FAST_NARROW_WS (FAST_NARROW_WS),
        .SLOW_WORD_WS   (SLOW_WORD_WS),
        .SLOW_NARROW_WS (SLOW_NARROW_WS)
    ) i_bus (
        .clk         (hclk),
        .rst_n       (hresetn),
        .hsel        (hsel),
        .haddr_lo    (haddr[REG_OFF_W-1:0]),
        .addr_win    (addr_win),
        .htrans      (htrans),
        .hwrite      (hwrite),
        .hsize       (hsize),
        .hwdata      (hwdata),
        .hready      (hready),
        .fast_mode   (fast_mode),
        .prog_busy   (prog_busy),
        .prog_done   (prog_done),
        .buf_rd_word (buf_rd_word),
        .hreadyout   (hreadyout),
        .hresp       (hresp),
        .hrdata      (hrdata),
        .buf_we      (buf_we),
        .buf_idx     (buf_idx),
        .buf_data    (buf_data),
        .buf_be      (buf_be),
        .buf_row     (buf_row),
        .buf_rd_idx  (buf_rd_idx),
        .start_pulse (start_pulse),
        .status_rd   (status_rd)
    );

    pgbuf_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W)) i_buf (
        .clk       (hclk),
        .rst_n     (hresetn),
        .wr_en     (buf_we),
        .wr_idx    (buf_idx),
        .wr_data   (buf_data),
        .wr_be     (buf_be),
        .wr_row    (buf_row),
        .clr       (buf_clr),
        .rd_idx    (buf_rd_idx),
        .rd_word   (buf_rd_word),
        .scan_idx  (scan_idx),
        .scan_data (mem_wdata),
        .scan_be   (scan_be),
        .row_q     (mem_row)
    );

    pgbuf_prog_seq #(.HW_CNT(HW_CNT), .PROG_CYCLES(PROG_CYCLES)) i_seq (
        .clk       (hclk),
        .rst_n     (hresetn),
        .start     (start_pulse),
        .status_rd (status_rd),
        .scan_be   (scan_be),
        .scan_idx  (scan_idx),
        .mem_we    (mem_we),
        .busy      (prog_busy),
        .done      (prog_done),
        .buf_clr   (buf_clr)
    );

    assign mem_col = scan_idx;
    assign mem_be  = scan_be;

endmodule

// File: rtl/pgbuf_write_ctrl_chk.sv
// Protocol and sequencing checker for the page-buffer write controller,
// attached to every instance of the top by the bind below.
module pgbuf_write_ctrl_chk #(
    parameter int MAX_WS = 7
) (
    input logic clk,
    input logic rst_n,
    input logic hreadyout,
    input logic hresp,
    input logic busy,
    input logic done,
    input logic mem_we,
    input logic buf_we
);

    logic [7:0] low_run;

    // Length of the current run of stalled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (!hreadyout) low_run <= low_run + 1'b1;
        else                 low_run <= '0;
    end

    AST_ERR_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout)); // R9
    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |-> (low_run < 8'(MAX_WS))); // R3
    AST_BUF_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we); // R8
    AST_ARRAY_WRITE_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R7
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R11

endmodule

bind pgbuf_write_ctrl pgbuf_write_ctrl_chk #(.MAX_WS(SLOW_WORD_WS)) i_chk (
    .clk       (hclk),
    .rst_n     (hresetn),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .busy      (prog_busy),
    .done      (prog_done),
    .mem_we    (mem_we),
    .buf_we    (buf_we)
);

// File: tb/test_pgbuf_write_ctrl.sv
// Directed bench for the page-buffer write controller.
module test_pgbuf_write_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [17:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd0;
    logic [31:0] hwdata = '0;
    logic        hready;
    logic        fast_mode = 1'b1;
    logic        hreadyout, hresp;
    logic [31:0] hrdata;
    logic        mem_we;
    logic [5:0]  mem_row;
    logic [4:0]  mem_col;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_be;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [17:0] PB = 18'h01140;   // row 5 of the EEPROM window

    assign hready = hreadyout;
    always #5 clk = ~clk;

    pgbuf_write_ctrl i_pgbuf_write_ctrl (
        .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
        .fast_mode(fast_mode), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col),
        .mem_wdata(mem_wdata), .mem_be(mem_be)
    );

    // Array-side capture, sampled mid-cycle.
    int          cap_n = 0;
    logic [4:0]  cap_col  [32];
    logic [15:0] cap_data [32];
    logic [1:0]  cap_be   [32];
    logic [5:0]  cap_row  [32];
    always @(negedge clk) begin
        if (mem_we && cap_n < 32) begin
            cap_col[cap_n]  = mem_col;
            cap_data[cap_n] = mem_wdata;
            cap_be[cap_n]   = mem_be;
            cap_row[cap_n]  = mem_row;
            cap_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [17:0] a, input logic w, input logic [2:0] s,
                        input logic [31:0] d, output int waits, output logic resp,
                        output logic [31:0] rd);
        @(negedge clk);
        hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = w; hsize = s;
        @(posedge clk);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = d;
        waits = 0;
        while (!hreadyout && waits < 20) begin
            waits++;
            @(negedge clk);
        end
        resp = hresp;
        rd = hrdata;
    endtask

    task automatic wr_expect(input string req, input logic [17:0] a, input logic [2:0] s,
                             input logic [31:0] d, input int exp_waits);
        int w; logic r; logic [31:0] q;
        xfer(a, 1'b1, s, d, w, r, q);
        chk(req, 32'(w), 32'(exp_waits));
        chk(req, {31'd0, r}, 32'd0);
    endtask

    task automatic rd_expect(input string req, input logic [17:0] a, input logic [31:0] exp);
        int w; logic r; logic [31:0] q;
        xfer(a, 1'b0, 3'd2, 32'd0, w, r, q);
        chk(req, 32'(w), 32'd0);
        chk(req, q, exp);
    endtask

    task automatic err_expect(input string req, input logic [17:0] a, input logic w_en);
        int w; logic r; logic [31:0] q;
        xfer(a, w_en, 3'd2, 32'hDEAD_BEEF, w, r, q);
        chk(req, 32'(w), 32'd1);
        chk(req, {31'd0, r}, 32'd1);
    endtask

    // R1: reset state.
    task automatic t_reset();
        chk("R1 hreadyout", {31'd0, hreadyout}, 32'd1);
        chk("R1 hresp", {31'd0, hresp}, 32'd0);
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        rd_expect("R1 status", 18'h00004, 32'd0);
        rd_expect("R1 buffer", PB, 32'd0);
    endtask

    // R2 and R5: fast mode stalls, word split, narrow lanes.
    task automatic t_fast();
        fast_mode = 1'b1;
        wr_expect("R2 word", PB + 18'h0, 3'd2, 32'h1122_3344, 5);
        wr_expect("R2 byte", PB + 18'h5, 3'd0, 32'h0000_AA00, 2);
        wr_expect("R2 half", PB + 18'hA, 3'd1, 32'hBEEF_0000, 2);
    endtask

    // R3: slow mode stalls.
    task automatic t_slow();
        fast_mode = 1'b0;
        wr_expect("R3 word", PB + 18'h10, 3'd2, 32'hCAFE_F00D, 7);
        wr_expect("R3 byte", PB + 18'h14, 3'd0, 32'h0000_005A, 3);
        wr_expect("R3 half", PB + 18'h16, 3'd1, 32'h1234_0000, 3);
        fast_mode = 1'b1;
    endtask

    // R4 and R5: buffer readback shows exact lanes touched.
    task automatic t_readback();
        rd_expect("R5 word halves", PB + 18'h0, 32'h1122_3344);
        rd_expect("R4 byte lane1", PB + 18'h4, 32'h0000_AA00);
        rd_expect("R4 half upper", PB + 18'h8, 32'hBEEF_0000);
        rd_expect("R5 slow word", PB + 18'h10, 32'hCAFE_F00D);
        rd_expect("R4 byte lane0 and half", PB + 18'h14, 32'h1234_005A);
    endtask

    // R10: flash window is acknowledged and inert.
    task automatic t_flash();
        wr_expect("R10 flash write", 18'h03010, 3'd2, 32'hFFFF_FFFF, 0);
        rd_expect("R10 flash read", 18'h03010, 32'd0);
        rd_expect("R10 buffer untouched", PB + 18'h10, 32'hCAFE_F00D);
    endtask

    // R9: undefined window answers with a two-cycle error.
    task automatic t_undef();
        err_expect("R9 undef write", 18'h02000, 1'b1);
        err_expect("R9 undef read", 18'h02010, 1'b0);
        err_expect("R9 above flash", 18'h2B000, 1'b0);
    endtask

    // R6, R7, R8, R11: program the page and observe the array side.
    task automatic t_program();
        int w; logic r; logic [31:0] q;
        logic [4:0]  ec [8];
        logic [15:0] ed [8];
        logic [1:0]  eb [8];
        int polls;
        ec = '{5'd0, 5'd1, 5'd2, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11};
        ed = '{16'h3344, 16'h1122, 16'hAA00, 16'hBEEF, 16'hF00D, 16'hCAFE, 16'h005A, 16'h1234};
        eb = '{2'b11, 2'b11, 2'b10, 2'b11, 2'b11, 2'b11, 2'b01, 2'b11};
        cap_n = 0;
        wr_expect("R6 start write", 18'h00000, 3'd2, 32'd1, 0);
        rd_expect("R6 busy set", 18'h00004, 32'd1);
        err_expect("R8 write while busy", PB + 18'h20, 1'b1);
        rd_expect("R8 buffer unchanged", PB + 18'h20, 32'd0);
        polls = 0;
        q = 32'd1;
        while (q[0] && polls < 200) begin
            xfer(18'h00004, 1'b0, 3'd2, 32'd0, w, r, q);
            polls++;
        end
        chk("R6 busy clears", {31'd0, q[0]}, 32'd0);
        chk("R11 done set", {31'd0, q[1]}, 32'd1);
        rd_expect("R11 done cleared by read", 18'h00004, 32'd0);
        chk("R7 write count", 32'(cap_n), 32'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R7 column", {27'd0, cap_col[i]}, {27'd0, ec[i]});
            chk("R7 data", {16'd0, cap_data[i]}, {16'd0, ed[i]});
            chk("R7 byte enables", {30'd0, cap_be[i]}, {30'd0, eb[i]});
            chk("R7 row", {26'd0, cap_row[i]}, 32'd5);
        end
        rd_expect("R11 buffer cleared", PB + 18'h0, 32'd0);
        rd_expect("R11 buffer cleared upper", PB + 18'h14, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast();
        t_slow();
        t_readback();
        t_flash();
        t_undef();
        t_program();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule